// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for every received frame, whether the frame is kept or discarded. It looks at the six-byte destination address, whether the frame carries a VLAN tag together with the 12-bit VLAN ID, and a small set of receive-control inputs. It works through a fixed order of checks: a VLAN gate, the promiscuous and broadcast modes, sixteen exact-match address entries, and a hash-based multicast table.

The three lookup tables are loaded over a simple write port. These are the exact-match entries, a 128-word multicast hash table and a 128-word VLAN filter table. Each decision appears one clock after the address is presented. It comes with pulses that mark an acceptance as broadcast or as multicast. Byte k of the destination address (k = 0 is the first byte on the wire) sits at `dstAddr[8k+7:8k]`.

Top module: `rx_addr_filter`

## Requirements
- R1: With `vlanFilterEn` high and `vlanTagged` high, the frame is dropped unless bit `vlanId[4:0]` of VLAN table word `vlanId[11:5]` is set. This check comes before every address check.
- R2: With `ucastPromisc` high, a frame whose `dstAddr[0]` is 0 (unicast) is accepted without pulses. Broadcast and multicast frames are not accepted by this mode.
- R3: With `mcastPromisc` high, a frame with `dstAddr[0]` = 1 is accepted and `mcastHit` pulses.
- R4: With `bcastAccept` high, an all-ones destination that was not already taken by R3 is accepted and `bcastHit` pulses.
- R5: Exact-match entries are written with `regSel` = 0. For entry e, `regIdx` = 2e writes address bytes 0..3 (byte 0 in bits 7:0), and `regIdx` = 2e+1 writes bytes 4..5 in bits 15:0 with the valid flag in bit 31. A full 48-bit match against a valid entry accepts the frame without pulses. An entry with the valid flag clear never matches.
- R6: The hash is bits 11:0 of `{byte5, byte4}` shifted right by 4, 3, 2 or 0 for `mcastOffset` = 0, 1, 2 or 3.
- R7: The hash table is written with `regSel` = 1 and the VLAN table with `regSel` = 2, with `regIdx` as the word index. If hash bit [4:0] of table word hash[11:5] is set, the frame is accepted and `mcastHit` pulses.
- R8: A frame that passes no check is dropped. `decValid`, `accept` and the pulses appear on the clock edge after the one that samples `dstValid`. A pulse is only ever high together with `accept`.
- R9: Reset clears all three tables and drives every output low.
- R10: The checks have a fixed priority. A multicast frame rejected by the other checks is dropped even in unicast-promiscuous mode. A broadcast frame with both `mcastPromisc` and `bcastAccept` high counts as multicast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ucastPromisc | input | 1 | Accept every unicast frame |
| mcastPromisc | input | 1 | Accept every multicast frame |
| bcastAccept | input | 1 | Accept broadcast frames |
| vlanFilterEn | input | 1 | Gate tagged frames through the VLAN table |
| mcastOffset | input | 2 | Hash window select |
| regWrEn | input | 1 | Table write strobe |
| regSel | input | 2 | Table select: 0 exact, 1 hash, 2 VLAN |
| regIdx | input | 7 | Word index within the selected table |
| regWrData | input | 32 | Write data |
| dstValid | input | 1 | Destination address valid this cycle |
| dstAddr | input | 48 | Destination address, byte 0 in bits 7:0 |
| vlanTagged | input | 1 | Frame carries a VLAN tag |
| vlanId | input | 12 | VLAN ID of the tagged frame |
| decValid | output | 1 | Decision valid |
| accept | output | 1 | Frame accepted |
| bcastHit | output | 1 | Accepted as broadcast |
| mcastHit | output | 1 | Accepted as multicast |

## Verification
The bench first sends unicast, multicast and broadcast frames with each mode enabled alone. This separates the three promiscuous and broadcast rules from one another and exposes the priority between them. Exact entries are then loaded with the valid flag clear and then set, which shows that the flag gates matching. The hash table is probed with all four window selects on addresses that hash differently per window, so a wrong shift shows up as a drop. Tagged frames are sent with the VLAN gate on while unicast promiscuous mode is also on, which shows the gate overrides every address rule. A long phase with random modes and addresses drawn from a pool that includes the table contents then compares against the model on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_W    = 48;
  localparam int VID_W     = 12;
  localparam int WORD_W    = 32;
  localparam int NUM_EXACT = 16;
  localparam int TBL_WORDS = 128;
  localparam int IDX_W     = $clog2(TBL_WORDS);

  typedef enum logic [1:0] {
    SEL_EXACT = 2'd0,
    SEL_HASH  = 2'd1,
    SEL_VLAN  = 2'd2,
    SEL_NONE  = 2'd3
  } tblSel_e;

  // write strobes from control to the table datapath
  typedef struct packed {
    logic              exLo;
    logic              exHi;
    logic              hash;
    logic              vlan;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] data;
  } tblWr_t;
endpackage

// File: rtl/rxf_tables.sv
module rxf_tables
  import rxf_pkg::*;
#(
  parameter int NUM_ENTRIES = NUM_EXACT,
  parameter int HASH_WORDS  = TBL_WORDS,
  parameter int VLAN_WORDS  = TBL_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblWr_t            wr,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [1:0]        mcastOffset,
  input  logic [VID_W-1:0]  vlanId,
  output logic              vlanBit,
  output logic              exactHit,
  output logic              hashBit
);
  localparam int EX_IDX_W = $clog2(NUM_ENTRIES);
  localparam int HASH_W   = $clog2(HASH_WORDS) + 5;

  logic [WORD_W-1:0] exLo    [NUM_ENTRIES];
  logic [WORD_W-1:0] exHi    [NUM_ENTRIES];
  logic [WORD_W-1:0] hashTbl [HASH_WORDS];
  logic [WORD_W-1:0] vlanTbl [VLAN_WORDS];
  logic [NUM_ENTRIES-1:0] matchVec;
  logic [15:0] hashSrc, hashShifted;
  logic [HASH_W-1:0] hashIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        exLo[i] <= '0;
        exHi[i] <= '0;
      end
      for (int i = 0; i < HASH_WORDS; i++) hashTbl[i] <= '0;
      for (int i = 0; i < VLAN_WORDS; i++) vlanTbl[i] <= '0;
    end else begin
      if (wr.exLo) exLo[wr.idx[EX_IDX_W:1]] <= wr.data;
      if (wr.exHi) exHi[wr.idx[EX_IDX_W:1]] <= wr.data;
      if (wr.hash) hashTbl[wr.idx] <= wr.data;
      if (wr.vlan) vlanTbl[wr.idx] <= wr.data;
    end
  end

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_exact
      assign matchVec[e] = exHi[e][31] &&
                           ({exHi[e][15:0], exLo[e]} == dstAddr);
    end
  endgenerate
  assign exactHit = |matchVec;

  assign hashSrc = dstAddr[47:32];
  always_comb begin
    case (mcastOffset)
      2'd0:    hashShifted = hashSrc >> 4;
      2'd1:    hashShifted = hashSrc >> 3;
      2'd2:    hashShifted = hashSrc >> 2;
      default: hashShifted = hashSrc;
    endcase
  end
  assign hashIdx = hashShifted[HASH_W-1:0];
  assign hashBit = hashTbl[hashIdx[HASH_W-1:5]][hashIdx[4:0]];
  assign vlanBit = vlanTbl[vlanId[VID_W-1:5]][vlanId[4:0]];

  // R5: an entry whose high word was just written with the flag clear cannot match next cycle
  p_invalid_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    wr.exHi && !wr.data[31] |=> !matchVec[$past(wr.idx[EX_IDX_W:1])]);
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ucastPromisc,
  input  logic              mcastPromisc,
  input  logic              bcastAccept,
  input  logic              vlanFilterEn,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [WORD_W-1:0] regWrData,
  input  logic              dstValid,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic              vlanTagged,
  input  logic              vlanBit,
  input  logic              exactHit,
  input  logic              hashBit,
  output tblWr_t            wr,
  output logic              decValid,
  output logic              accept,
  output logic              bcastHit,
  output logic              mcastHit
);
  logic isMcast, isBcast, vlanDrop;
  logic nAcc, nBc, nMc;

  always_comb begin
    wr.exLo = regWrEn && (regSel == SEL_EXACT) && !regIdx[0];
    wr.exHi = regWrEn && (regSel == SEL_EXACT) &&  regIdx[0];
    wr.hash = regWrEn && (regSel == SEL_HASH);
    wr.vlan = regWrEn && (regSel == SEL_VLAN);
    wr.idx  = regIdx;
    wr.data = regWrData;
  end

  assign isMcast  = dstAddr[0];
  assign isBcast  = &dstAddr;
  assign vlanDrop = vlanFilterEn && vlanTagged && !vlanBit;

  always_comb begin
    nAcc = 1'b0;
    nBc  = 1'b0;
    nMc  = 1'b0;
    if (vlanDrop) begin
      nAcc = 1'b0;
    end else if (ucastPromisc && !isMcast) begin
      nAcc = 1'b1;
    end else if (mcastPromisc && isMcast) begin
      nAcc = 1'b1;
      nMc  = 1'b1;
    end else if (bcastAccept && isBcast) begin
      nAcc = 1'b1;
      nBc  = 1'b1;
    end else if (exactHit) begin
      nAcc = 1'b1;
    end else if (hashBit) begin
      nAcc = 1'b1;
      nMc  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid <= 1'b0;
      accept   <= 1'b0;
      bcastHit <= 1'b0;
      mcastHit <= 1'b0;
    end else begin
      decValid <= dstValid;
      accept   <= dstValid && nAcc;
      bcastHit <= dstValid && nBc;
      mcastHit <= dstValid && nMc;
    end
  end

  p_vlan_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    dstValid && vlanFilterEn && vlanTagged && !vlanBit |=> decValid && !accept);
  p_ucast_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    dstValid && ucastPromisc && !dstAddr[0] && !(vlanFilterEn && vlanTagged && !vlanBit)
    |=> accept && !bcastHit && !mcastHit);
  p_mcast_promisc_r3: assert property (@(posedge clk) disable iff (!rstN)
    dstValid && mcastPromisc && dstAddr[0] && !(vlanFilterEn && vlanTagged && !vlanBit)
    |=> accept && mcastHit && !bcastHit);
  p_bcast_r4: assert property (@(posedge clk) disable iff (!rstN)
    dstValid && bcastAccept && !mcastPromisc && (&dstAddr) &&
    !(vlanFilterEn && vlanTagged && !vlanBit) |=> accept && bcastHit);
  p_pulse_with_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bcastHit || mcastHit) |-> accept && decValid && !(bcastHit && mcastHit));
  p_latency_r8: assert property (@(posedge clk) disable iff (!rstN)
    dstValid |=> decValid);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ucastPromisc,
  input  logic        mcastPromisc,
  input  logic        bcastAccept,
  input  logic        vlanFilterEn,
  input  logic [1:0]  mcastOffset,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [6:0]  regIdx,
  input  logic [31:0] regWrData,
  input  logic        dstValid,
  input  logic [47:0] dstAddr,
  input  logic        vlanTagged,
  input  logic [11:0] vlanId,
  output logic        decValid,
  output logic        accept,
  output logic        bcastHit,
  output logic        mcastHit
);
  tblWr_t wr;
  logic vlanBit, exactHit, hashBit;

  rxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .ucastPromisc(ucastPromisc), .mcastPromisc(mcastPromisc),
    .bcastAccept(bcastAccept), .vlanFilterEn(vlanFilterEn),
    .regWrEn(regWrEn), .regSel(regSel), .regIdx(regIdx), .regWrData(regWrData),
    .dstValid(dstValid), .dstAddr(dstAddr), .vlanTagged(vlanTagged),
    .vlanBit(vlanBit), .exactHit(exactHit), .hashBit(hashBit),
    .wr(wr), .decValid(decValid), .accept(accept),
    .bcastHit(bcastHit), .mcastHit(mcastHit)
  );

  rxf_tables u_tables (
    .clk(clk), .rstN(rstN), .wr(wr), .dstAddr(dstAddr),
    .mcastOffset(mcastOffset), .vlanId(vlanId),
    .vlanBit(vlanBit), .exactHit(exactHit), .hashBit(hashBit)
  );
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb;
  logic clk = 0, rstN = 0;
  logic cUpe = 0, cMpe = 0, cBam = 0, cVlanEn = 0;
  logic [1:0] cOff = 0;
  logic regWrEn = 0;
  logic [1:0] regSel = 0;
  logic [6:0] regIdx = 0;
  logic [31:0] regWrData = 0;
  logic dstValid = 0, vlanTagged = 0;
  logic [47:0] dstAddr = 0;
  logic [11:0] vlanId = 0;
  logic decValid, accept, bcastHit, mcastHit;

  int errors = 0, checks = 0;
  bit done = 0;

  // reference state
  bit [31:0] mExLo[16], mExHi[16], mHash[128], mVlan[128];
  bit eV, eA, eB, eM;
  string eTag;

  rx_addr_filter u_dut (
    .clk(clk), .rstN(rstN), .ucastPromisc(cUpe), .mcastPromisc(cMpe),
    .bcastAccept(cBam), .vlanFilterEn(cVlanEn), .mcastOffset(cOff),
    .regWrEn(regWrEn), .regSel(regSel), .regIdx(regIdx), .regWrData(regWrData),
    .dstValid(dstValid), .dstAddr(dstAddr), .vlanTagged(vlanTagged), .vlanId(vlanId),
    .decValid(decValid), .accept(accept), .bcastHit(bcastHit), .mcastHit(mcastHit)
  );

  always #5 clk = ~clk;

  function automatic int hashOf(bit [47:0] a, int off);
    int v, sh;
    v = a[47:40] * 256 + a[39:32];
    case (off)
      0: sh = 4;
      1: sh = 3;
      2: sh = 2;
      default: sh = 0;
    endcase
    return (v >> sh) % 4096;
  endfunction

  task automatic decide(input bit [47:0] a, input bit tg, input bit [11:0] vid,
                        output bit acc, output bit b, output bit m, output string tag);
    bit mc, bc, found;
    int h;
    mc = a[0];
    bc = (a == 48'hFFFF_FFFF_FFFF);
    acc = 0; b = 0; m = 0; found = 0;
    if (cVlanEn && tg && mVlan[vid / 32][vid % 32] == 1'b0) tag = "R1";
    else if (cUpe && !mc) begin acc = 1; tag = "R2"; end
    else if (cMpe && mc) begin acc = 1; m = 1; tag = bc ? "R3 R10" : "R3"; end
    else if (cBam && bc) begin acc = 1; b = 1; tag = "R4"; end
    else begin
      for (int e = 0; e < 16; e++)
        if (mExHi[e][31] && mExHi[e][15:0] == a[47:32] && mExLo[e] == a[31:0]) found = 1;
      if (found) begin acc = 1; tag = "R5"; end
      else begin
        h = hashOf(a, cOff);
        if (mHash[h / 32][h % 32]) begin acc = 1; m = 1; tag = "R6 R7"; end
        else tag = (cUpe && mc) ? "R10" : "R8";
      end
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin mExLo[i] = 0; mExHi[i] = 0; end
      for (int i = 0; i < 128; i++) begin mHash[i] = 0; mVlan[i] = 0; end
      eV = 0; eA = 0; eB = 0; eM = 0; eTag = "R9";
    end else begin
      bit a, b, m;
      string t;
      eV = dstValid;
      if (dstValid) begin
        decide(dstAddr, vlanTagged, vlanId, a, b, m, t);
        eA = a; eB = b; eM = m; eTag = t;
      end else begin
        eA = 0; eB = 0; eM = 0; eTag = "R8";
      end
      if (regWrEn) begin
        case (regSel)
          2'd0: if (regIdx[0]) mExHi[regIdx[4:1]] = regWrData;
                else mExLo[regIdx[4:1]] = regWrData;
          2'd1: mHash[regIdx] = regWrData;
          2'd2: mVlan[regIdx] = regWrData;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if ({decValid, accept, bcastHit, mcastHit} !== {eV, eA, eB, eM}) begin
        errors++;
        $display("FAIL %s: {valid,accept,bcast,mcast} actual=%b%b%b%b expected=%b%b%b%b",
                 eTag, decValid, accept, bcastHit, mcastHit, eV, eA, eB, eM);
      end
    end
  end

  task automatic wreg(input bit [1:0] sel, input int idx, input bit [31:0] d);
    @(negedge clk);
    regWrEn = 1; regSel = sel; regIdx = 7'(idx); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic setExact(input int e, input bit [47:0] a, input bit v);
    wreg(2'd0, 2 * e, a[31:0]);
    wreg(2'd0, 2 * e + 1, {v, 15'b0, a[47:32]});
  endtask

  task automatic setHash(input bit [47:0] a);
    int h;
    h = hashOf(a, cOff);
    wreg(2'd1, h / 32, mHash[h / 32] | (32'd1 << (h % 32)));
  endtask

  task automatic setVlan(input int vid);
    wreg(2'd2, vid / 32, mVlan[vid / 32] | (32'd1 << (vid % 32)));
  endtask

  task automatic frame(input bit [47:0] a, input bit tg, input bit [11:0] vid);
    @(negedge clk);
    dstValid = 1; dstAddr = a; vlanTagged = tg; vlanId = vid;
    @(negedge clk);
    dstValid = 0;
  endtask

  task automatic cfg(input bit u, input bit m, input bit b, input bit v, input bit [1:0] o);
    @(negedge clk);
    cUpe = u; cMpe = m; cBam = b; cVlanEn = v; cOff = o;
  endtask

  localparam bit [47:0] UC  = 48'h5544_3322_1100;
  localparam bit [47:0] MC  = 48'h0FED_CBA9_8701;
  localparam bit [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam bit [47:0] EX3 = 48'hA1B2_C3D4_E5F6;
  localparam bit [47:0] EXF = 48'h1357_9BDF_0246;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({decValid, accept, bcastHit, mcastHit} !== 4'b0) begin
      errors++;
      $display("FAIL R9: outputs under reset actual=%b%b%b%b expected=0000",
               decValid, accept, bcastHit, mcastHit);
    end
    rstN = 1;
    // R9: cleared tables, no modes: everything dropped (R8)
    frame(UC, 0, 0); frame(MC, 0, 0); frame(BC, 1, 12'd7);
    // R2 / R10: unicast promiscuous only
    cfg(1, 0, 0, 0, 0);
    frame(UC, 0, 0); frame(MC, 0, 0); frame(BC, 0, 0);
    // R3
    cfg(0, 1, 0, 0, 0);
    frame(MC, 0, 0); frame(UC, 0, 0); frame(BC, 0, 0);
    // R4, and R10 broadcast counted as multicast
    cfg(0, 0, 1, 0, 0);
    frame(BC, 0, 0); frame(MC, 0, 0);
    cfg(0, 1, 1, 0, 0);
    frame(BC, 0, 0);
    // R5: valid flag gates matching
    cfg(0, 0, 0, 0, 0);
    setExact(3, EX3, 0);
    frame(EX3, 0, 0);
    setExact(3, EX3, 1);
    setExact(15, EXF, 1);
    frame(EX3, 0, 0); frame(EXF, 0, 0); frame(EX3 ^ 48'h1, 0, 0);
    // R6 R7: each window select
    for (int o = 0; o < 4; o++) begin
      bit [47:0] a;
      a = {8'(8'h3C + 17 * o), 8'(8'h9A + 29 * o), 32'h1122_3301};
      cfg(0, 0, 0, 0, 2'(o));
      frame(a, 0, 0);
      setHash(a);
      frame(a, 0, 0);
      for (int p = 0; p < 4; p++) begin
        cfg(0, 0, 0, 0, 2'(p));
        frame(a, 0, 0);
      end
    end
    // R1: VLAN gate overrides everything
    cfg(1, 1, 1, 1, 0);
    frame(UC, 1, 12'd100); frame(BC, 1, 12'd100); frame(EX3, 1, 12'd100);
    frame(UC, 0, 12'd100);
    setVlan(100);
    frame(UC, 1, 12'd100); frame(UC, 1, 12'd101); frame(MC, 1, 12'd4095);
    setVlan(4095);
    frame(MC, 1, 12'd4095);
    // random phase
    for (int n = 0; n < 600; n++) begin
      bit [47:0] a;
      case ($urandom % 6)
        0: a = UC ^ {16'h0, 32'($urandom) & 32'hFFFF_FFFE};
        1: a = {16'($urandom), 32'($urandom)} | 48'h1;
        2: a = BC;
        3: a = EX3;
        4: a = EXF;
        default: a = {16'($urandom), 32'($urandom)};
      endcase
      if ($urandom % 4 == 0) cfg(1'($urandom), 1'($urandom), 1'($urandom),
                                 1'($urandom), 2'($urandom));
      if ($urandom % 16 == 0) setHash(a);
      if ($urandom % 16 == 0) setVlan($urandom % 128);
      frame(a, 1'($urandom), 12'($urandom % 128));
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule